// File: doc/BRIEF.md
# Differential SAR Conversion Sequencer

This block is the digital control for a 16-bit successive-approximation converter with a differential input. A rising edge on the convert trigger starts one conversion. The conversion runs on the block's own clock, and the serial read-out clock plays no part in it. Once started, it always runs to the end.

Each trial sets one bit of an offset-binary trial level, starting at the most significant bit. The trial level goes out to an external comparator. One clock later the block samples the comparator's keep decision, and keeps or clears that bit. After the least significant trial, the block does three things in one step:

- It turns the offset-binary code into a two's-complement result by inverting the top bit.
- It raises a one-cycle done strobe, with the result valid in that same cycle.
- It drops busy.

It then sits in a quiet acquisition state. In that state the trial level is parked at zero until the next trigger.

The comparator and the capacitor array are outside the block. The comparator signals that the differential input is at or above the level the trial code stands for. Because of this, inputs beyond either end of the range settle naturally on the clamped end codes.

Top module: `sar_seq`

## Requirements
- R1: A conversion starts only on a low-to-high transition of `convStart` seen while idle, and `busy` is high in the cycle after that edge. A level held high does not start another conversion. A `convStart` already high when reset is released does not start one.
- R2: Once started, a conversion runs to completion whatever `convStart` does. Transitions of `convStart` while `busy` is high are ignored. `busy` stays high for exactly 18 cycles: one setup cycle, 16 trial cycles and one finish cycle.
- R3: `trialLevel` is an offset-binary code, where value 32768 stands for a zero differential input. The first trial is 0x8000, in the second busy cycle. In each trial cycle, a high `cmpKeep` keeps the bit under trial and a low one clears it. The next lower bit is then set for the following trial, and the order runs from bit 15 down to bit 0.
- R4: `done` is a one-cycle pulse in the first cycle after `busy` falls. `result` carries the new code in that same cycle, so there is no extra latency.
- R5: `result` is two's complement with midscale at zero. For example, a differential input of 0 LSB gives 0x0000, +1 LSB gives 0x0001, −1 LSB gives 0xFFFF and −2 LSB gives 0xFFFE.
- R6: An input above +32767 LSB saturates to 0x7FFF. An input at or below −32768 LSB gives 0x8000.
- R7: While `busy` is low, `trialLevel` is 0. `result` holds its value between conversions, whatever the comparator does.
- R8: During and right after reset, `busy`, `done`, `result` and `trialLevel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rstN | input | 1 | Active-low synchronous reset |
| convStart | input | 1 | Convert trigger; the rising edge starts a conversion |
| cmpKeep | input | 1 | Comparator decision: input is at or above the current trial level |
| trialLevel | output | 16 | Offset-binary trial code driven to the comparator |
| busy | output | 1 | High while a conversion is in progress |
| done | output | 1 | One-cycle strobe; `result` is new in this cycle |
| result | output | 16 | Two's-complement conversion result |

## Verification
The bench goes after the codes around zero, where an error in the top-bit inversion would turn ±1 LSB into codes near the ends of the scale. It also drives inputs far beyond either end of the range; a wrong keep/clear rule there would produce wrapped codes instead of 0x7FFF and 0x8000. It toggles the trigger during a conversion and holds it high through reset, because edge detection that is level-sensitive or not gated by the busy state would restart the conversion and change its length or its result. The bench also follows the first two trial levels, to catch a bit order that runs the wrong way or loses the kept bit.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_TRIAL,
    ST_FINISH
  } seqState_t;

  // Strobes from the sequencer control to the trial datapath
  typedef struct packed {
    logic load;    // seed the trial register with the top bit
    logic step;    // resolve the bit under trial and move down one
    logic finish;  // publish the result and park the trial level
  } seqCtrl_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     convStart,
  output seqCtrl_t ctrl,
  output logic     busy,
  output logic     done
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  seqState_t       state;
  logic            convPrev;
  logic            convRise;
  logic [CNT_W-1:0] bitCnt;
  logic            doneReg;

  assign convRise = convStart & ~convPrev;

  // Reset to one so a trigger held high through reset is not an edge
  always_ff @(posedge clk) begin
    if (!rstN) convPrev <= 1'b1;
    else       convPrev <= convStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= (state == ST_FINISH);
      unique case (state)
        ST_IDLE: begin
          if (convRise) state <= ST_SETUP;
        end
        ST_SETUP: begin
          bitCnt <= LAST_IDX;
          state  <= ST_TRIAL;
        end
        ST_TRIAL: begin
          if (bitCnt == '0) state <= ST_FINISH;
          else              bitCnt <= bitCnt - 1'b1;
        end
        ST_FINISH: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load   = (state == ST_SETUP);
    ctrl.step   = (state == ST_TRIAL);
    ctrl.finish = (state == ST_FINISH);
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;

endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtrl_t         ctrl,
  input  logic             cmpKeep,
  output logic [WIDTH-1:0] trialLevel,
  output logic [WIDTH-1:0] result
);

  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trialReg;
  logic [WIDTH-1:0] maskReg;
  logic [WIDTH-1:0] resolved;
  logic [WIDTH-1:0] nextMask;
  logic [WIDTH-1:0] twosCode;

  // Per-bit resolution: only the bit under trial may be cleared
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign resolved[i] = trialReg[i] & (cmpKeep | ~maskReg[i]);
  end

  assign nextMask = maskReg >> 1;
  assign twosCode = {~trialReg[WIDTH-1], trialReg[WIDTH-2:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trialReg <= '0;
      maskReg  <= '0;
    end else if (ctrl.load) begin
      trialReg <= TOP_BIT;
      maskReg  <= TOP_BIT;
    end else if (ctrl.step) begin
      trialReg <= resolved | nextMask;
      maskReg  <= nextMask;
    end else if (ctrl.finish) begin
      trialReg <= '0;
      maskReg  <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            result <= '0;
    else if (ctrl.finish) result <= twosCode;
  end

  assign trialLevel = trialReg;

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic             cmpKeep,
  output logic [WIDTH-1:0] trialLevel,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  seqCtrl_t ctrl;

  sar_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .convStart (convStart),
    .ctrl      (ctrl),
    .busy      (busy),
    .done      (done)
  );

  sar_seq_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .cmpKeep    (cmpKeep),
    .trialLevel (trialLevel),
    .result     (result)
  );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             convStart,
  input logic [WIDTH-1:0] trialLevel,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);

  localparam int BUSY_CYC = WIDTH + 2;
  localparam int BC_W     = $clog2(BUSY_CYC + 2) + 1;
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [BC_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  // R1: busy only rises after a cycle with the trigger high
  a_r1_start_on_trigger: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(convStart));

  // R2: a conversion always lasts the full length
  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == BC_W'(BUSY_CYC)));

  // R3: the first trial after setup is the top bit alone
  a_r3_first_trial: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> (trialLevel == TOP_BIT));

  // R4: done lasts one cycle
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: done comes right after the conversion ends
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R7: the trial level is parked while idle
  a_r7_idle_trial: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (trialLevel == '0));

  // R7: the result changes only with done
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

endmodule

bind sar_seq sar_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .convStart  (convStart),
  .trialLevel (trialLevel),
  .busy       (busy),
  .done       (done),
  .result     (result)
);

// File: tb/tb_sar_seq.sv
module tb_sar_seq;

  localparam int WIDTH  = 16;
  localparam int HALF   = 32768;
  localparam int NVEC   = 12;
  localparam int BUSY_N = 18;

  // Differential input in LSBs and the expected code (R5, R6)
  localparam int          VEC_IN  [NVEC] = '{0, 1, -1, -2, 256, 12345, -12345,
                                             32767, -32767, -32768, 40000, -40000};
  localparam logic [15:0] VEC_EXP [NVEC] = '{16'h0000, 16'h0001, 16'hFFFF, 16'hFFFE,
                                             16'h0100, 16'h3039, 16'hCFC7, 16'h7FFF,
                                             16'h8001, 16'h8000, 16'h7FFF, 16'h8000};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             convStart = 1'b0;
  logic             cmpKeep;
  logic [WIDTH-1:0] trialLevel;
  logic             busy;
  logic             done;
  logic [WIDTH-1:0] result;
  int               vin = 0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  // Behavioural comparator: input at or above the trial level
  assign cmpKeep = (vin >= (int'(trialLevel) - HALF));

  sar_seq #(.WIDTH(WIDTH)) dut (
    .clk        (clk),
    .rstN       (rstN),
    .convStart  (convStart),
    .cmpKeep    (cmpKeep),
    .trialLevel (trialLevel),
    .busy       (busy),
    .done       (done),
    .result     (result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // One conversion; wiggle toggles the trigger while busy (R2)
  task automatic runConv(input int v, input logic [15:0] exp, input bit wiggle, input string tag);
    int cyc;
    vin = v;
    @(negedge clk) convStart = 1'b0;
    @(negedge clk) convStart = 1'b1;
    @(negedge clk);
    check(busy === 1'b1, "R1", int'(busy), 1);
    cyc = 1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (busy !== 1'b1) break;
      cyc++;
      if (wiggle) convStart = ~convStart;
    end
    check(cyc == BUSY_N, "R2", cyc, BUSY_N);
    check(done === 1'b1, "R4", int'(done), 1);
    check(result === exp, tag, int'(result), int'(exp));
    @(negedge clk);
    check(done === 1'b0, "R4", int'(done), 0);
    convStart = 1'b0;
  endtask

  // Follow the first two trial levels (R3)
  task automatic traceTrial(input int v, input logic [15:0] exp2);
    vin = v;
    @(negedge clk) convStart = 1'b0;
    @(negedge clk) convStart = 1'b1;
    @(negedge clk);
    check(trialLevel === 16'h0000, "R3", int'(trialLevel), 0);
    @(negedge clk);
    check(trialLevel === 16'h8000, "R3", int'(trialLevel), 16'h8000);
    @(negedge clk);
    check(trialLevel === exp2, "R3", int'(trialLevel), int'(exp2));
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (busy !== 1'b1) break;
    end
    @(negedge clk) convStart = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2: watchdog expired, actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    logic [15:0] held;

    // R8 and R1: trigger held high across reset release
    convStart = 1'b1;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R8", int'({busy, done}), 0);
    check(result === '0 && trialLevel === '0, "R8", int'(result | trialLevel), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R1", int'(busy), 0);

    // Vector table (R5, R6)
    for (int i = 0; i < NVEC; i++) begin
      runConv(VEC_IN[i], VEC_EXP[i], 1'b0, (i >= 7) ? "R6" : "R5");
    end

    // R2: trigger toggling during the conversion
    runConv(-300, 16'hFED4, 1'b1, "R2");
    runConv(9, 16'h0009, 1'b1, "R2");

    // R1: level held high does not restart
    vin = 5;
    @(negedge clk) convStart = 1'b1;
    for (int k = 0; k < 25; k++) @(negedge clk);
    convStart = 1'b1;
    for (int k = 0; k < 5; k++) @(negedge clk);
    check(busy === 1'b0, "R1", int'(busy), 0);
    check(result === 16'h0005, "R1", int'(result), 5);
    convStart = 1'b0;

    // R7: idle trial level and held result while the comparator moves
    held = result;
    vin = -20000;
    repeat (6) @(negedge clk);
    check(trialLevel === '0, "R7", int'(trialLevel), 0);
    check(result === held, "R7", int'(result), int'(held));
    vin = 20000;
    repeat (3) @(negedge clk);
    check(result === held, "R7", int'(result), int'(held));

    // R3: bit order and the keep/clear rule
    traceTrial(0, 16'hC000);
    traceTrial(-1, 16'h4000);

    finishRun();
  end

endmodule